// File: doc/BRIEF.md
# Quadrature Decoder with Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a signed position. The A and B phases arrive without any timing relation to the clock. Each phase first passes through a synchronizer chain. Every change of a single phase then produces a one-cycle count strobe and a direction level. The block counts both the rising and the falling edges of both phases, so it counts four times per encoder line.

The strobe and the direction level are outputs of the block. Inside, they also drive an up/down accumulator that holds the position as a two's-complement value, which wraps around at its width. If both phases change between two samples, the step cannot be resolved. The block then counts nothing and raises a one-cycle error pulse instead.

Top module: `qdec_top`

## Requirements
- R1: While `rst` is high, and at the first clock after it falls, `position` reads 0 and `cnt_en` and `phase_err` are low. The synchronized phase state present during reset becomes the comparison history, so releasing reset with either phase high causes no count.
- R2: A change of exactly one phase at the pins raises `cnt_en` for exactly one clock cycle. Measured from the clock edge that first samples the change, `cnt_en` is high after the third edge (two synchronizer stages plus one decode register).
- R3: Rising and falling edges on A and on B are each counted, giving four counts per full encoder cycle.
- R4: `dir_up` equals current A XOR previous B, and it is valid whenever `cnt_en` is high. With the phase pair written as {A,B}, the sequence 00, 10, 11, 01 (A leads B) gives `dir_up` = 1. The reverse order gives 0.
- R5: When A and B both change between two consecutive synchronized samples, `cnt_en` stays low and `phase_err` is high for one cycle. `cnt_en` and `phase_err` are never high together.
- R6: `position` increases by 1 in the cycle after `cnt_en` is high with `dir_up` = 1, and decreases by 1 in the cycle after `cnt_en` is high with `dir_up` = 0.
- R7: `position` wraps modulo 2^POS_W. One down count from 0 gives all ones.
- R8: `position` holds its value in any cycle that follows a cycle with `cnt_en` low, whether the phases are steady or the step was illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | Raw phase A, asynchronous |
| b_in | input | 1 | Raw phase B, asynchronous |
| cnt_en | output | 1 | One-cycle strobe per legal single-phase edge |
| dir_up | output | 1 | Direction: 1 = up (A leads B), 0 = down |
| phase_err | output | 1 | One-cycle pulse on a simultaneous change of both phases |
| position | output | POS_W (32) | Signed position accumulator |

## Verification
The bench applies slow forward motion with several idle cycles per step. This separates a strobe that lasts one cycle from a level, and it shows the three-cycle latency. Fast reverse motion, with a new phase state on every clock, gives back-to-back strobes and drives the count below zero, which exercises the wrap. Deliberate jumps in which both phases change, and a reset applied while a phase is high, show that the error path and the reset history load never count. A final stretch of random toggles with random hold times mixes direction reversals, legal steps and illegal steps.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  // Phase pair packing: bit 1 = A, bit 0 = B
  typedef logic [1:0] phase_t;

  function automatic logic one_phase_moved(input phase_t now_s, input phase_t was_s);
    return (now_s[1] ^ was_s[1]) ^ (now_s[0] ^ was_s[0]);
  endfunction

  function automatic logic both_phases_moved(input phase_t now_s, input phase_t was_s);
    return (now_s[1] ^ was_s[1]) & (now_s[0] ^ was_s[0]);
  endfunction

  // Up when current A differs from previous B
  function automatic logic heading_up(input phase_t now_s, input phase_t was_s);
    return now_s[1] ^ was_s[0];
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    chain[0] <= d;
    for (int i = 1; i < STAGES; i++) begin
      chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];

  initial begin
    a_stages_min : assert (STAGES >= 2);
  end
endmodule

// File: rtl/qdec_edge.sv
module qdec_edge
  import qdec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t cur,
  output logic   en,
  output logic   up,
  output logic   err
);
  phase_t hist;
  logic   single_chg;
  logic   both_chg;
  logic   up_now;

  assign single_chg = one_phase_moved(cur, hist);
  assign both_chg   = both_phases_moved(cur, hist);
  assign up_now     = heading_up(cur, hist);

  always_ff @(posedge clk) begin
    hist <= cur;
    if (rst) begin
      en  <= 1'b0;
      up  <= 1'b0;
      err <= 1'b0;
    end else begin
      en  <= single_chg;
      up  <= up_now;
      err <= both_chg;
    end
  end

  a_r5_exclusive : assert property (@(posedge clk) disable iff (rst)
    !(en && err));

  a_r2_en_cause : assert property (@(posedge clk) disable iff (rst)
    en |-> $past(single_chg));

  a_r5_err_cause : assert property (@(posedge clk) disable iff (rst)
    err |-> $past(both_chg));

  a_r4_forward_step : assert property (@(posedge clk) disable iff (rst)
    (hist == 2'b00 && cur == 2'b10) |=> (en && up));

  a_r4_reverse_step : assert property (@(posedge clk) disable iff (rst)
    (hist == 2'b10 && cur == 2'b00) |=> (en && !up));
endmodule

// File: rtl/qdec_position.sv
module qdec_position #(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             up,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  function automatic logic [POS_W-1:0] advance(input logic [POS_W-1:0] p,
                                               input logic e, input logic u);
    if (!e)     return p;
    else if (u) return p + ONE;
    else        return p - ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= advance(pos, en, up);
  end

  a_r6_count_up : assert property (@(posedge clk) disable iff (rst)
    (en && up) |=> (pos == $past(pos) + ONE));

  a_r6_count_down : assert property (@(posedge clk) disable iff (rst)
    (en && !up) |=> (pos == $past(pos) - ONE));

  a_r8_hold : assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pos));
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_in,
  input  logic             b_in,
  output logic             cnt_en,
  output logic             dir_up,
  output logic             phase_err,
  output logic [POS_W-1:0] position
);
  phase_t phase_s;

  qdec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({a_in, b_in}),
    .q   (phase_s)
  );

  qdec_edge u_edge (
    .clk (clk),
    .rst (rst),
    .cur (phase_s),
    .en  (cnt_en),
    .up  (dir_up),
    .err (phase_err)
  );

  qdec_position #(.POS_W(POS_W)) u_pos (
    .clk (clk),
    .rst (rst),
    .en  (cnt_en),
    .up  (dir_up),
    .pos (position)
  );

  a_r1_after_reset : assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (position == '0 && !cnt_en && !phase_err));
endmodule

// File: tb/qdec_top_test.sv
`timescale 1ns/1ps
module qdec_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_in = 1'b0;
  logic        b_in = 1'b0;
  logic        cnt_en;
  logic        dir_up;
  logic        phase_err;
  logic [31:0] position;

  always #5 clk = ~clk;

  qdec_top uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .cnt_en(cnt_en), .dir_up(dir_up), .phase_err(phase_err), .position(position)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // Behavioural reference: remember every sampled input pair
  logic [1:0]  seen[$];
  logic        m_en = 0, m_up = 0, m_err = 0;
  logic [31:0] m_pos = 0;

  always @(posedge clk) begin
    seen.push_back({a_in, b_in});
    if (rst) begin
      m_en = 0; m_err = 0; m_pos = 0;
    end else begin
      int n;
      logic [1:0] newer, older;
      n = seen.size();
      if (m_en) m_pos = m_up ? m_pos + 32'd1 : m_pos - 32'd1;
      newer = seen[n-3];
      older = seen[n-4];
      m_en  = (newer[1] != older[1]) != (newer[0] != older[0]);
      m_err = (newer[1] != older[1]) && (newer[0] != older[0]);
      m_up  = newer[1] ^ older[0];
    end
  end

  task automatic check_now();
    vectors++;
    if (cnt_en !== m_en) begin
      errors++;
      $display("FAIL R2/R3/R5 cnt_en=%0b expected %0b t=%0t", cnt_en, m_en, $time);
    end
    if (phase_err !== m_err) begin
      errors++;
      $display("FAIL R5 phase_err=%0b expected %0b t=%0t", phase_err, m_err, $time);
    end
    if (m_en && dir_up !== m_up) begin
      errors++;
      $display("FAIL R4 dir_up=%0b expected %0b t=%0t", dir_up, m_up, $time);
    end
    if (position !== m_pos) begin
      errors++;
      $display("FAIL R1/R6/R7/R8 position=%h expected %h t=%0t", position, m_pos, $time);
    end
  endtask

  task automatic tick(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic put(logic [1:0] v, int hold);
    @(negedge clk);
    check_now();
    a_in = v[1];
    b_in = v[0];
    tick(hold);
  endtask

  function automatic logic [1:0] gray(int idx);
    case (idx & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  int g = 0;

  initial begin
    // R1: reset state
    tick(6);
    rst = 1'b0;
    tick(3);
    // R2 R3 R4 R6: slow forward motion
    for (int s = 0; s < 20; s++) begin g++; put(gray(g), 4); end
    if (position !== 32'd20) begin
      errors++; $display("FAIL R6 position=%0d expected 20", position);
    end
    vectors++;
    // R7: fast reverse through zero
    for (int s = 0; s < 30; s++) begin g--; put(gray(g), 0); end
    tick(5);
    if (position !== 32'hFFFF_FFF6) begin
      errors++; $display("FAIL R7 position=%h expected fffffff6", position);
    end
    vectors++;
    // R5 R8: illegal jumps
    put(gray(g + 2), 5);
    g = g + 2;
    put(gray(g + 2), 5);
    g = g + 2;
    // R1: reset while a phase is high, release without spurious count
    g++; put(gray(g), 4);
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(6);
    g++; put(gray(g), 4);
    // mixed random motion
    for (int s = 0; s < 400; s++) begin
      logic [1:0] v;
      v = {a_in, b_in};
      case ($urandom_range(0, 5))
        0, 1: v[1] = ~v[1];
        2, 3: v[0] = ~v[0];
        4:    v = ~v;
        default: ;
      endcase
      put(v, $urandom_range(0, 3));
    end
    tick(6);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule